// File: doc/BRIEF.md
# Tight Schedule Checker for Clustered Processor Arrays

This block decides whether a linear timing vector for a three-deep loop nest keeps one physical processor of a clustered (locally sequential, globally parallel) array fully busy without collisions. Each physical processor serves a rectangular group of virtual processors of size `dim_x` by `dim_y`. Virtual processor coordinates are the first two loop indices. Iterations belonging to one virtual processor are separated along the third loop index. A schedule is tight when every virtual processor in the group gets its own slot within the period `dim_x*dim_y`, and the processor is never idle.

The block does not replay the schedule. It applies an exact number-theoretic test. The third timing entry must equal the group size. One of the first two entries must be a scaled copy of a group dimension, and the scaled factors and raw entries must be coprime to the matching dimensions. The test is done under both orderings of the two group dimensions. The block uses one iterative divider and one iterative GCD unit, both shared across the steps. A caller pulses `start` with operands on the ports, waits for the one-cycle `done` pulse, and reads the verdict, which ordering matched, and a flag for a degenerate group.

Top module: `sched_tight_check`

## Requirements
- R1: After reset, `busy`, `done`, `tight`, `bad_shape` and `order_hit` are all 0.
- R2: A `start` pulse seen while `busy` is 0 latches the operands and raises `busy` on the next cycle. A `start` seen while `busy` is 1 is ignored and does not change the result of the operation in progress.
- R3: Each accepted operation ends with `done` high for exactly one cycle. `busy` is 0 in that cycle.
- R4: `tight` can be 1 only when `sch_z` equals `dim_x*dim_y`, compared as unsigned values.
- R5: `order_hit[0]` (natural ordering) is 1 only when all of the following hold. `sch_z` equals `dim_x*dim_y`. `sch_y` is an exact multiple of `dim_x`. gcd(`sch_x`, `dim_x`) = 1. gcd(`sch_y`/`dim_x`, `dim_y`) = 1. Here gcd(0, n) = n.
- R6: `order_hit[1]` (swapped ordering) is 1 only when all of the following hold. `sch_z` equals `dim_x*dim_y`. `sch_x` is an exact multiple of `dim_y`. gcd(`sch_x`/`dim_y`, `dim_x`) = 1. gcd(`sch_y`, `dim_y`) = 1.
- R7: `tight` is 1 exactly when, with `sch_z` equal to the period P = `dim_x*dim_y`, the values (`sch_x`*a + `sch_y`*b) mod P are all distinct for 0 ≤ a < `dim_x` and 0 ≤ b < `dim_y`. This is the same as `tight` = `order_hit[0]` | `order_hit[1]`.
- R8: If `dim_x` or `dim_y` is 0, the block reports `bad_shape` = 1, `tight` = 0 and `order_hit` = 0.
- R9: `tight`, `order_hit` and `bad_shape` hold their values from `done` until the next accepted operation finishes, whatever the inputs do.
- R10: For the group (4,5), the vector (7,4,20) is tight with `order_hit` = 2'b01. The vector (15,3,20) is tight with `order_hit` = 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a check; accepted only while idle |
| dim_x | input | W | First group dimension |
| dim_y | input | W | Second group dimension |
| sch_x | input | W | Timing entry for the first loop index |
| sch_y | input | W | Timing entry for the second loop index |
| sch_z | input | W | Timing entry along the projection direction |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| tight | output | 1 | Schedule is tight for the group |
| order_hit | output | 2 | Bit 0 natural ordering matched, bit 1 swapped ordering matched |
| bad_shape | output | 1 | A group dimension was zero |

## Verification
A quotient or remainder latched into the wrong step, or a GCD started with stale operands, shows up as a wrong `order_hit` bit in the same `done` pulse that ends the operation. The sweep catches this by comparing against a brute-force slot-collision count and a direct coprimality formula. A sequencer that skips or repeats a step shows up as a changed pulse latency or a missing `done`. A result register that reloads outside the evaluation step shows up as output drift in the idle cycles after `done`.

// File: rtl/tls_pkg.sv
package tls_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DIV_X,
      ST_GCD_X1,
      ST_GCD_X2,
      ST_DIV_Y,
      ST_GCD_Y1,
      ST_GCD_Y2,
      ST_EVAL
   } step_e;

   localparam int ORD_NATURAL = 0;
   localparam int ORD_SWAPPED = 1;
   localparam int ORD_COUNT   = 2;
endpackage

// File: rtl/tls_divider.sv
module tls_divider #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic         fin,
   output logic [W-1:0] quo,
   output logic [W-1:0] rem
);
   localparam int CW = $clog2(W + 1);

   logic         run;
   logic [CW-1:0] cnt;
   logic [W-1:0] q_r;
   logic [W-1:0] r_r;
   logic [W:0]   trial;
   logic [W:0]   den_ext;

   assign trial   = {r_r, q_r[W-1]};
   assign den_ext = {1'b0, den};
   assign quo     = q_r;
   assign rem     = r_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         cnt <= '0;
         q_r <= '0;
         r_r <= '0;
         fin <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            run <= 1'b1;
            cnt <= CW'(W);
            q_r <= num;
            r_r <= '0;
         end else if (run) begin
            if (trial >= den_ext) begin
               r_r <= W'(trial - den_ext);
               q_r <= {q_r[W-2:0], 1'b1};
            end else begin
               r_r <= trial[W-1:0];
               q_r <= {q_r[W-2:0], 1'b0};
            end
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
               run <= 1'b0;
               fin <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/tls_gcd.sv
module tls_gcd #(
   parameter int W    = 16,
   parameter int ALGO = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         fin,
   output logic [W-1:0] g
);
   localparam int KW = $clog2(W + 1);

   generate
      if (ALGO == 0) begin : g_binary
         logic          run;
         logic [W-1:0]  x;
         logic [W-1:0]  y;
         logic [KW-1:0] k;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run <= 1'b0;
               x   <= '0;
               y   <= '0;
               k   <= '0;
               fin <= 1'b0;
               g   <= '0;
            end else begin
               fin <= 1'b0;
               if (go) begin
                  run <= 1'b1;
                  k   <= '0;
                  if (b == '0) begin
                     x <= '0;
                     y <= a;
                  end else begin
                     x <= a;
                     y <= b;
                  end
               end else if (run) begin
                  if (x == '0) begin
                     run <= 1'b0;
                     fin <= 1'b1;
                     g   <= y << k;
                  end else if (!x[0] && !y[0]) begin
                     x <= x >> 1;
                     y <= y >> 1;
                     k <= k + 1'b1;
                  end else if (!x[0]) begin
                     x <= x >> 1;
                  end else if (!y[0]) begin
                     y <= y >> 1;
                  end else if (x >= y) begin
                     x <= (x - y) >> 1;
                  end else begin
                     y <= (y - x) >> 1;
                  end
               end
            end
         end
      end else begin : g_subtract
         logic         run;
         logic [W-1:0] x;
         logic [W-1:0] y;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run <= 1'b0;
               x   <= '0;
               y   <= '0;
               fin <= 1'b0;
               g   <= '0;
            end else begin
               fin <= 1'b0;
               if (go) begin
                  run <= 1'b1;
                  if (b == '0) begin
                     x <= '0;
                     y <= a;
                  end else begin
                     x <= a;
                     y <= b;
                  end
               end else if (run) begin
                  if (x == '0) begin
                     run <= 1'b0;
                     fin <= 1'b1;
                     g   <= y;
                  end else if (x > y) begin
                     x <= x - y;
                  end else if (y > x) begin
                     y <= y - x;
                  end else begin
                     x <= '0;
                  end
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sched_tight_check.sv
module sched_tight_check
   import tls_pkg::*;
#(
   parameter int W        = 16,
   parameter int GCD_ALGO = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [W-1:0]         dim_x,
   input  logic [W-1:0]         dim_y,
   input  logic [W-1:0]         sch_x,
   input  logic [W-1:0]         sch_y,
   input  logic [W-1:0]         sch_z,
   output logic                 busy,
   output logic                 done,
   output logic                 tight,
   output logic [ORD_COUNT-1:0] order_hit,
   output logic                 bad_shape
);
   localparam int PW = 2 * W;
   localparam logic [W-1:0] ONE = W'(1);

   generate
      if (W < 2) begin : g_chk_width
         $error("sched_tight_check: W must be at least 2");
      end
      if (GCD_ALGO != 0 && GCD_ALGO != 1) begin : g_chk_algo
         $error("sched_tight_check: GCD_ALGO must be 0 or 1");
      end
   endgenerate

   step_e        step;
   logic         launched;
   logic         bad_q;
   logic [W-1:0] dx_q, dy_q, sx_q, sy_q, sz_q;
   logic [W-1:0] qx_q, rx_q, gx1_q, gx2_q;
   logic [W-1:0] qy_q, ry_q, gy1_q, gy2_q;

   logic         div_go, div_fin;
   logic [W-1:0] div_num, div_den, div_quo, div_rem;
   logic         gcd_go, gcd_fin;
   logic [W-1:0] gcd_a, gcd_b, gcd_g;
   logic         is_div, is_gcd;

   logic [PW-1:0] gamma_w;
   logic          z_ok;
   logic          hit_nat, hit_swp;

   assign gamma_w = {{W{1'b0}}, dx_q} * {{W{1'b0}}, dy_q};
   assign z_ok    = ({{W{1'b0}}, sz_q} == gamma_w);
   assign hit_nat = z_ok && (rx_q == '0) && (gx1_q == ONE) && (gx2_q == ONE);
   assign hit_swp = z_ok && (ry_q == '0) && (gy1_q == ONE) && (gy2_q == ONE);

   assign is_div = (step == ST_DIV_X) || (step == ST_DIV_Y);
   assign is_gcd = (step == ST_GCD_X1) || (step == ST_GCD_X2) ||
                   (step == ST_GCD_Y1) || (step == ST_GCD_Y2);
   assign div_go = is_div && !launched;
   assign gcd_go = is_gcd && !launched;
   assign busy   = (step != ST_IDLE);

   always_comb begin
      div_num = sy_q;
      div_den = dx_q;
      if (step == ST_DIV_Y) begin
         div_num = sx_q;
         div_den = dy_q;
      end
      gcd_a = '0;
      gcd_b = '0;
      case (step)
         ST_GCD_X1: begin gcd_a = sx_q; gcd_b = dx_q; end
         ST_GCD_X2: begin gcd_a = qx_q; gcd_b = dy_q; end
         ST_GCD_Y1: begin gcd_a = sy_q; gcd_b = dy_q; end
         ST_GCD_Y2: begin gcd_a = qy_q; gcd_b = dx_q; end
         default:   begin gcd_a = '0;   gcd_b = '0;   end
      endcase
   end

   tls_divider #(.W(W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (div_go),
      .num   (div_num),
      .den   (div_den),
      .fin   (div_fin),
      .quo   (div_quo),
      .rem   (div_rem)
   );

   tls_gcd #(.W(W), .ALGO(GCD_ALGO)) u_gcd (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (gcd_go),
      .a     (gcd_a),
      .b     (gcd_b),
      .fin   (gcd_fin),
      .g     (gcd_g)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step      <= ST_IDLE;
         launched  <= 1'b0;
         bad_q     <= 1'b0;
         dx_q      <= '0;
         dy_q      <= '0;
         sx_q      <= '0;
         sy_q      <= '0;
         sz_q      <= '0;
         qx_q      <= '0;
         rx_q      <= '0;
         gx1_q     <= '0;
         gx2_q     <= '0;
         qy_q      <= '0;
         ry_q      <= '0;
         gy1_q     <= '0;
         gy2_q     <= '0;
         done      <= 1'b0;
         tight     <= 1'b0;
         order_hit <= '0;
         bad_shape <= 1'b0;
      end else begin
         done <= 1'b0;
         if (div_go || gcd_go) begin
            launched <= 1'b1;
         end
         case (step)
            ST_IDLE: begin
               if (start) begin
                  dx_q     <= dim_x;
                  dy_q     <= dim_y;
                  sx_q     <= sch_x;
                  sy_q     <= sch_y;
                  sz_q     <= sch_z;
                  launched <= 1'b0;
                  if (dim_x == '0 || dim_y == '0) begin
                     bad_q <= 1'b1;
                     step  <= ST_EVAL;
                  end else begin
                     bad_q <= 1'b0;
                     step  <= ST_DIV_X;
                  end
               end
            end
            ST_DIV_X: if (div_fin) begin
               qx_q     <= div_quo;
               rx_q     <= div_rem;
               launched <= 1'b0;
               step     <= ST_GCD_X1;
            end
            ST_GCD_X1: if (gcd_fin) begin
               gx1_q    <= gcd_g;
               launched <= 1'b0;
               step     <= ST_GCD_X2;
            end
            ST_GCD_X2: if (gcd_fin) begin
               gx2_q    <= gcd_g;
               launched <= 1'b0;
               step     <= ST_DIV_Y;
            end
            ST_DIV_Y: if (div_fin) begin
               qy_q     <= div_quo;
               ry_q     <= div_rem;
               launched <= 1'b0;
               step     <= ST_GCD_Y1;
            end
            ST_GCD_Y1: if (gcd_fin) begin
               gy1_q    <= gcd_g;
               launched <= 1'b0;
               step     <= ST_GCD_Y2;
            end
            ST_GCD_Y2: if (gcd_fin) begin
               gy2_q    <= gcd_g;
               launched <= 1'b0;
               step     <= ST_EVAL;
            end
            ST_EVAL: begin
               done      <= 1'b1;
               bad_shape <= bad_q;
               if (bad_q) begin
                  tight     <= 1'b0;
                  order_hit <= '0;
               end else begin
                  tight                  <= hit_nat | hit_swp;
                  order_hit[ORD_NATURAL] <= hit_nat;
                  order_hit[ORD_SWAPPED] <= hit_swp;
               end
               step <= ST_IDLE;
            end
            default: step <= ST_IDLE;
         endcase
      end
   end
endmodule

module sched_tight_check_sva #(
   parameter int W = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic           busy,
   input logic           done,
   input logic           tight,
   input logic [1:0]     order_hit,
   input logic           bad_shape,
   input logic [W-1:0]   lat_z,
   input logic [2*W-1:0] lat_gamma
);
   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && tight) |-> ({{W{1'b0}}, lat_z} == lat_gamma));

   assert_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && bad_shape) |-> (!tight && order_hit == 2'b00));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy) && !$past(start)) |->
         ($stable(tight) && $stable(order_hit) && $stable(bad_shape)));
endmodule

bind sched_tight_check sched_tight_check_sva #(.W(W)) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .tight     (tight),
   .order_hit (order_hit),
   .bad_shape (bad_shape),
   .lat_z     (sz_q),
   .lat_gamma (gamma_w)
);

// File: tb/test_sched_tight_check.sv
module test_sched_tight_check;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] dim_x = '0, dim_y = '0, sch_x = '0, sch_y = '0, sch_z = '0;
   logic        busy, done, tight, bad_shape;
   logic [1:0]  order_hit;
   int          checks = 0;
   int          errors = 0;

   always #10 clk = ~clk;

   sched_tight_check #(.W(16), .GCD_ALGO(0)) i_sched_tight_check (
      .clk(clk), .rst_n(rst_n), .start(start),
      .dim_x(dim_x), .dim_y(dim_y), .sch_x(sch_x), .sch_y(sch_y), .sch_z(sch_z),
      .busy(busy), .done(done), .tight(tight), .order_hit(order_hit),
      .bad_shape(bad_shape)
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int gcd_f(int a, int b);
      while (b != 0) begin
         int t = a % b;
         a = b;
         b = t;
      end
      return a;
   endfunction

   function automatic bit distinct_f(int c1, int c2, int a, int b);
      logic [63:0] seen = '0;
      int p = c1 * c2;
      for (int i = 0; i < c1; i++) begin
         for (int j = 0; j < c2; j++) begin
            int t = (a * i + b * j) % p;
            if (seen[t]) return 1'b0;
            seen[t] = 1'b1;
         end
      end
      return 1'b1;
   endfunction

   task automatic launch(int c1, int c2, int a, int b, int z);
      @(negedge clk);
      dim_x = 16'(c1); dim_y = 16'(c2);
      sch_x = 16'(a);  sch_y = 16'(b); sch_z = 16'(z);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R2 busy after start", busy, 1);
   endtask

   task automatic wait_done();
      int n = 0;
      while (!done && n < 4000) begin
         @(negedge clk);
         n++;
      end
      chk("R3 done seen", done, 1);
      chk("R3 busy low at done", busy, 0);
   endtask

   task automatic expect_result(int c1, int c2, int a, int b, int z);
      bit bad = (c1 == 0) || (c2 == 0);
      bit zok = !bad && (z == c1 * c2);
      bit e_nat = 0, e_swp = 0, e_t = 0;
      if (zok) begin
         e_nat = (b % c1 == 0) && gcd_f(a, c1) == 1 && gcd_f(b / c1, c2) == 1;
         e_swp = (a % c2 == 0) && gcd_f(a / c2, c1) == 1 && gcd_f(b, c2) == 1;
         e_t   = distinct_f(c1, c2, a, b);
      end
      chk("R8 bad_shape", bad_shape, bad);
      chk("R5 natural hit", order_hit[0], e_nat);
      chk("R6 swapped hit", order_hit[1], e_swp);
      chk("R7 tight vs slot collisions", tight, e_t);
      if (!zok) chk("R4 wrong period never tight", tight, 0);
   endtask

   task automatic run_case(int c1, int c2, int a, int b, int z);
      launch(c1, c2, a, b, z);
      wait_done();
      expect_result(c1, c2, a, b, z);
      @(negedge clk);
      chk("R3 done single cycle", done, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 busy reset", busy, 0);
      chk("R1 done reset", done, 0);
      chk("R1 tight reset", tight, 0);
      chk("R1 order_hit reset", order_hit, 0);
      chk("R1 bad_shape reset", bad_shape, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 known points
      run_case(4, 5, 7, 4, 20);
      chk("R10 natural example tight", tight, 1);
      chk("R10 natural example hit", order_hit, 1);
      run_case(4, 5, 15, 3, 20);
      chk("R10 swapped example tight", tight, 1);
      chk("R10 swapped example hit", order_hit, 2);
      run_case(4, 5, 7, 4, 21);
      run_case(4, 5, 6, 4, 20);

      // R8 degenerate groups
      run_case(0, 3, 1, 1, 0);
      run_case(3, 0, 1, 1, 0);
      run_case(0, 0, 0, 0, 0);

      // R2 start while busy is ignored
      launch(4, 5, 7, 4, 20);
      repeat (3) @(negedge clk);
      dim_x = 16'd0; dim_y = 16'd0; sch_x = 16'd2; sch_y = 16'd2; sch_z = 16'd0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      chk("R2 ignored start tight", tight, 1);
      chk("R2 ignored start hit", order_hit, 1);
      chk("R2 ignored start bad", bad_shape, 0);

      // R9 results hold while idle
      dim_x = 16'd3; dim_y = 16'd3; sch_x = 16'd1; sch_y = 16'd3; sch_z = 16'd9;
      repeat (6) @(negedge clk);
      chk("R9 hold tight", tight, 1);
      chk("R9 hold hit", order_hit, 1);
      chk("R9 hold bad", bad_shape, 0);

      // R5 R6 R7 sweep with matching period
      for (int c1 = 1; c1 <= 4; c1++)
         for (int c2 = 1; c2 <= 4; c2++)
            for (int a = 0; a <= 6; a++)
               for (int b = 0; b <= 6; b++)
                  run_case(c1, c2, a, b, c1 * c2);

      // R4 sweep with wrong period
      for (int c1 = 1; c1 <= 3; c1++)
         for (int c2 = 1; c2 <= 3; c2++)
            for (int a = 0; a <= 3; a++) begin
               run_case(c1, c2, a, 1, c1 * c2 + 1);
               run_case(c1, c2, 1, a, 0);
            end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule